// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors that sit in a small on-chip descriptor memory. A host programs each descriptor over a simple register bus. Every descriptor is two 32-bit words: a status/length word, then a buffer address word. When the status word of the descriptor at the engine's current index carries the ready flag, the engine passes the buffer address, the length and the per-frame flags to a frame sender. It then waits for the sender's completion report.

On completion the engine merges the reported status bits into the status word and clears the ready flag, which returns the descriptor to the host. It then moves to the next index. The ring closes either at a descriptor whose wrap flag is set or at the programmed descriptor count, whichever comes first. Descriptors that request it raise a frame-sent or a send-error interrupt source. Each source is cleared by writing one to it, and a mask decides which sources drive the interrupt output.

The memory holds `MAX_DESC` descriptors. The transmit ring uses the first `count` of them, and the entries after those remain available to the host for other use.

Top module: `tx_desc_ring`

## Requirements
- R1: After reset the mode, interrupt source and mask registers read 0, the descriptor count reads MAX_DESC, `irq` is low and `snd_req` is low.
- R2: Register byte offsets are: 0x00 mode (bit 0 transmit enable), 0x04 interrupt source, 0x08 interrupt mask, 0x0C descriptor count. A count write above MAX_DESC stores MAX_DESC. Descriptor i has its status word at 0x400+8*i and its address word at 0x404+8*i, and host writes to these words read back unchanged.
- R3: While enabled, a descriptor whose status bit 15 (ready) is set is offered on the sender port. `snd_addr` is its address word, `snd_pad` is bit 12 and `snd_crc` is bit 11. `snd_req` and these values stay stable until `snd_done`.
- R4: `snd_len` equals status bits 31:16. The one exception is that when bit 12 is set and the length is below 64, `snd_len` is 64.
- R5: After completion the status word keeps bits 31:16 and 14:9, clears bit 15, and takes the sender's status in bits 8:0. The sender's status bits are: bit 0 carrier lost, bit 1 deferred, bit 2 late collision, bit 3 retry limit, bits 7:4 retry count, bit 8 underrun. The address word is unchanged.
- R6: The index advances by one per finished descriptor, and after a descriptor with bit 13 (wrap) set the next index is 0.
- R7: After finishing index count-1 the next index is 0 even without a wrap bit.
- R8: A finished descriptor with bit 14 set sets source bit 1 if any of status bits 0, 2, 3 or 8 is reported, and otherwise sets source bit 0. Deferral and retry count alone are not errors. With bit 14 clear the source register is unchanged.
- R9: Writing 1 to a source bit clears it, and writing 0 leaves it. `irq` is high exactly when some source bit and its mask bit are both set.
- R10: While transmit enable is 0 no descriptor is started, a ready descriptor stays untouched, and the index returns to 0.
- R11: A descriptor with ready clear is not sent. The engine waits at that index until ready is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| snd_req | output | 1 | Frame offered to sender |
| snd_addr | output | 32 | Buffer address of offered frame |
| snd_len | output | 16 | Length to send, after padding |
| snd_pad | output | 1 | Pad flag of the frame |
| snd_crc | output | 1 | CRC append flag of the frame |
| snd_done | input | 1 | Sender completion pulse |
| snd_stat | input | 9 | Completion status bits |
| irq | output | 1 | Masked interrupt output |

## Verification
The bench builds the block with MAX_DESC of 8 and the 64-byte minimum frame, so eight descriptors cover the whole ring. With that size the bench can reach both ring-closing rules and repeated laps at a programmed count of 4 and of 8. It also drives every completion status bit one at a time through the error classification. Lengths around the 64-byte floor are swept with padding on and off, and the bench tracks the expected index itself to predict which buffer address must appear next.

// File: rtl/txring_pkg.sv
package txring_pkg;

  typedef enum logic [1:0] {ST_POLL, ST_SEND, ST_WB} eng_state_t;

  // Length actually handed to the sender after the padding rule.
  function automatic logic [15:0] sent_length(input logic [15:0] len,
                                              input logic pad,
                                              input logic [15:0] min_len);
    return (pad && (len < min_len)) ? min_len : len;
  endfunction

  // Completion status bits that count as a failed send.
  function automatic logic is_error(input logic [8:0] st);
    return st[0] | st[2] | st[3] | st[8];
  endfunction

  // Status word written back when a descriptor is retired.
  function automatic logic [31:0] retire_word(input logic [15:0] len,
                                              input logic [5:0] ctl,
                                              input logic [8:0] st);
    return {len, 1'b0, ctl, st};
  endfunction

endpackage

// File: rtl/txring_regs.sv
module txring_regs #(
  parameter int MAX_DESC = 128,
  localparam int CNT_W = $clog2(MAX_DESC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       sel,
  input  logic [31:0]      wdata,
  input  logic             done_evt,
  input  logic             err_evt,
  output logic             tx_en,
  output logic [CNT_W-1:0] count,
  output logic [1:0]       src,
  output logic [1:0]       mask,
  output logic             irq
);

  function automatic logic [CNT_W-1:0] clamp_count(input logic [31:0] v);
    return (v > 32'(MAX_DESC)) ? CNT_W'(MAX_DESC) : CNT_W'(v);
  endfunction

  logic       src_we;
  logic [1:0] clr_bits;

  assign src_we   = wr && (sel == 2'd1);
  assign clr_bits = src_we ? wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en <= 1'b0;
      src   <= 2'b00;
      mask  <= 2'b00;
      count <= CNT_W'(MAX_DESC);
    end else begin
      if (wr && sel == 2'd0) tx_en <= wdata[0];
      if (wr && sel == 2'd2) mask  <= wdata[1:0];
      if (wr && sel == 2'd3) count <= clamp_count(wdata);
      src <= (src & ~clr_bits) | {err_evt, done_evt};
    end
  end

  assign irq = |(src & mask);

  p_count_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(MAX_DESC));

  p_done_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> src[0]);

  p_err_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> src[1]);

  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_we && wdata[0] && !done_evt) |=> !src[0]);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 2'b00) |-> !irq);

endmodule

// File: rtl/txring_mem.sv
module txring_mem #(
  parameter int MAX_DESC = 128,
  localparam int IDX_W = $clog2(MAX_DESC),
  localparam int WADDR_W = IDX_W + 1,
  localparam int MEM_WORDS = 2 * MAX_DESC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [WADDR_W-1:0] host_widx,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rword,
  input  logic [IDX_W-1:0]   eng_idx,
  input  logic               eng_we,
  input  logic [31:0]        eng_wdata,
  output logic               eng_ready,
  output logic [15:0]        eng_len,
  output logic [5:0]         eng_ctl,
  output logic [31:0]        eng_addr
);

  logic [31:0]        words [MEM_WORDS];
  logic [WADDR_W-1:0] stat_widx;
  logic [WADDR_W-1:0] addr_widx;
  logic [31:0]        stat_word;

  assign stat_widx = {eng_idx, 1'b0};
  assign addr_widx = {eng_idx, 1'b1};

  // The engine write comes last, so it wins on a same-word collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) words[i] <= '0;
    end else begin
      if (host_we) words[host_widx] <= host_wdata;
      if (eng_we)  words[stat_widx] <= eng_wdata;
    end
  end

  assign host_rword = words[host_widx];
  assign stat_word  = words[stat_widx];
  assign eng_ready  = stat_word[15];
  assign eng_len    = stat_word[31:16];
  assign eng_ctl    = stat_word[14:9];
  assign eng_addr   = words[addr_widx];

  p_retire_clears_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |=> !words[$past(stat_widx)][15]);

endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txring_pkg::*;
#(
  parameter int MAX_DESC = 128,
  parameter int MIN_FRAME = 64,
  localparam int IDX_W = $clog2(MAX_DESC),
  localparam int CNT_W = $clog2(MAX_DESC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [CNT_W-1:0] count,
  input  logic             ready_in,
  input  logic [15:0]      len_in,
  input  logic [5:0]       ctl_in,
  input  logic [31:0]      addr_in,
  input  logic             snd_done,
  input  logic [8:0]       snd_stat,
  output logic [IDX_W-1:0] idx,
  output logic             snd_req,
  output logic [31:0]      snd_addr,
  output logic [15:0]      snd_len,
  output logic             snd_pad,
  output logic             snd_crc,
  output logic             wb_we,
  output logic [31:0]      wb_word,
  output logic             done_evt,
  output logic             err_evt
);

  // ctl holds status bits 14:9: [5] irq, [4] wrap, [3] pad, [2] crc, [1:0] spare
  eng_state_t       state;
  logic [15:0]      cur_len;
  logic [5:0]       cur_ctl;
  logic [31:0]      cur_addr;
  logic [8:0]       cur_stat;
  logic [IDX_W-1:0] next_idx;
  logic             start_evt;
  logic             last_slot;
  logic             fail;

  assign start_evt = (state == ST_POLL) && tx_en && ready_in;
  assign last_slot = cur_ctl[4] || ((CNT_W'(idx) + CNT_W'(1)) >= count);
  assign next_idx  = last_slot ? '0 : idx + IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_POLL;
      idx      <= '0;
      cur_len  <= '0;
      cur_ctl  <= '0;
      cur_addr <= '0;
      cur_stat <= '0;
    end else begin
      unique case (state)
        ST_POLL: begin
          if (!tx_en) begin
            idx <= '0;
          end else if (start_evt) begin
            cur_len  <= len_in;
            cur_ctl  <= ctl_in;
            cur_addr <= addr_in;
            state    <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (snd_done) begin
            cur_stat <= snd_stat;
            state    <= ST_WB;
          end
        end
        ST_WB: begin
          idx   <= next_idx;
          state <= ST_POLL;
        end
        default: state <= ST_POLL;
      endcase
    end
  end

  assign snd_req  = (state == ST_SEND);
  assign snd_addr = cur_addr;
  assign snd_len  = sent_length(cur_len, cur_ctl[3], 16'(MIN_FRAME));
  assign snd_pad  = cur_ctl[3];
  assign snd_crc  = cur_ctl[2];

  assign fail     = is_error(cur_stat);
  assign wb_we    = (state == ST_WB);
  assign wb_word  = retire_word(cur_len, cur_ctl, cur_stat);
  assign done_evt = wb_we && cur_ctl[5] && !fail;
  assign err_evt  = wb_we && cur_ctl[5] && fail;

  p_req_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_req && !snd_done) |=> (snd_req && $stable(snd_addr) && $stable(snd_len)));

  p_pad_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_req && snd_pad) |-> (snd_len >= 16'(MIN_FRAME)));

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |=> ((idx == '0) || (idx == $past(idx) + IDX_W'(1))));

  p_count_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && (CNT_W'(idx) + CNT_W'(1) == count)) |=> (idx == '0));

  p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_POLL) && !tx_en) |=> ((idx == '0) && !snd_req));

endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring #(
  parameter int MAX_DESC = 128,
  parameter int MIN_FRAME = 64,
  parameter int ADDR_W = 12,
  localparam int IDX_W = $clog2(MAX_DESC),
  localparam int CNT_W = $clog2(MAX_DESC + 1),
  localparam int WADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              snd_req,
  output logic [31:0]       snd_addr,
  output logic [15:0]       snd_len,
  output logic              snd_pad,
  output logic              snd_crc,
  input  logic              snd_done,
  input  logic [8:0]        snd_stat,
  output logic              irq
);

  logic               reg_hit, desc_hit;
  logic [WADDR_W-1:0] desc_widx;
  logic [31:0]        desc_rword;
  logic               tx_en;
  logic [CNT_W-1:0]   count;
  logic [1:0]         src, mask;
  logic [IDX_W-1:0]   eng_idx;
  logic               eng_ready;
  logic [15:0]        eng_len;
  logic [5:0]         eng_ctl;
  logic [31:0]        eng_addr;
  logic               wb_we;
  logic [31:0]        wb_word;
  logic               done_evt, err_evt;

  assign reg_hit   = (host_addr[1:0] == 2'b00) && (host_addr[ADDR_W-1:4] == '0);
  assign desc_hit  = (host_addr[1:0] == 2'b00) && (host_addr >= ADDR_W'(1024));
  assign desc_widx = WADDR_W'((host_addr - ADDR_W'(1024)) >> 2);

  txring_regs #(.MAX_DESC(MAX_DESC)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr(host_wr && reg_hit), .sel(host_addr[3:2]), .wdata(host_wdata),
    .done_evt(done_evt), .err_evt(err_evt),
    .tx_en(tx_en), .count(count), .src(src), .mask(mask), .irq(irq)
  );

  txring_mem #(.MAX_DESC(MAX_DESC)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_wr && desc_hit), .host_widx(desc_widx),
    .host_wdata(host_wdata), .host_rword(desc_rword),
    .eng_idx(eng_idx), .eng_we(wb_we), .eng_wdata(wb_word),
    .eng_ready(eng_ready), .eng_len(eng_len), .eng_ctl(eng_ctl),
    .eng_addr(eng_addr)
  );

  txring_engine #(.MAX_DESC(MAX_DESC), .MIN_FRAME(MIN_FRAME)) u_eng (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .count(count),
    .ready_in(eng_ready), .len_in(eng_len), .ctl_in(eng_ctl),
    .addr_in(eng_addr), .snd_done(snd_done), .snd_stat(snd_stat),
    .idx(eng_idx), .snd_req(snd_req), .snd_addr(snd_addr),
    .snd_len(snd_len), .snd_pad(snd_pad), .snd_crc(snd_crc),
    .wb_we(wb_we), .wb_word(wb_word), .done_evt(done_evt), .err_evt(err_evt)
  );

  always_comb begin
    host_rdata = '0;
    if (desc_hit) begin
      host_rdata = desc_rword;
    end else if (reg_hit) begin
      unique case (host_addr[3:2])
        2'd0: host_rdata = {31'b0, tx_en};
        2'd1: host_rdata = {30'b0, src};
        2'd2: host_rdata = {30'b0, mask};
        default: host_rdata = 32'(count);
      endcase
    end
  end

endmodule

// File: tb/tx_desc_ring_bench.sv
module tx_desc_ring_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NDESC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        snd_req, snd_pad, snd_crc, irq;
  logic [31:0] snd_addr;
  logic [15:0] snd_len;
  logic        snd_done = 1'b0;
  logic [8:0]  snd_stat = '0;

  int checks = 0;
  int fails = 0;
  int exp_idx = 0;
  int count_m = NDESC;
  int serial = 0;
  logic [1:0] src_exp = 2'b00;
  logic [1:0] mask_m = 2'b00;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tx_desc_ring #(.MAX_DESC(NDESC), .MIN_FRAME(64), .ADDR_W(12)) u_tx_desc_ring (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .snd_req(snd_req),
    .snd_addr(snd_addr), .snd_len(snd_len), .snd_pad(snd_pad),
    .snd_crc(snd_crc), .snd_done(snd_done), .snd_stat(snd_stat), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  function automatic int nxt(input int i, input logic wrap);
    return (wrap || (i + 1 >= count_m)) ? 0 : i + 1;
  endfunction

  function automatic logic [11:0] saddr(input int i);
    return 12'(1024 + 8 * i);
  endfunction

  // Offer/accept one frame; sender replies with st.
  task automatic serve(input string tag, input logic [31:0] ea, input logic [15:0] el,
                       input logic ep, input logic ec, input logic [8:0] st);
    bit seen = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (snd_req) begin seen = 1; break; end
    end
    check({tag, " req seen"}, 32'(seen), 32'd1);
    if (seen) begin
      check({tag, " R3 addr"}, snd_addr, ea);
      check({tag, " R4 len"}, 32'(snd_len), 32'(el));
      check({tag, " R3 pad/crc"}, {30'b0, snd_pad, snd_crc}, {30'b0, ep, ec});
      snd_done = 1'b1; snd_stat = st;
      @(negedge clk);
      snd_done = 1'b0; snd_stat = '0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic after_frame(input string tag, input logic [31:0] w_exp, input logic [31:0] a_exp,
                             input logic irqen, input logic [8:0] st);
    logic [31:0] rd;
    logic err;
    hread(saddr(exp_idx), rd);
    check({tag, " R5 status word"}, rd, w_exp);
    hread(saddr(exp_idx) + 12'd4, rd);
    check({tag, " R5 addr word"}, rd, a_exp);
    err = st[0] | st[2] | st[3] | st[8];
    if (irqen) src_exp = src_exp | (err ? 2'b10 : 2'b01);
    hread(12'h004, rd);
    check({tag, " R8 source"}, rd, {30'b0, src_exp});
    check({tag, " R9 irq"}, 32'(irq), 32'(|(src_exp & mask_m)));
  endtask

  task automatic frame(input string tag, input logic [15:0] len, input logic pad, input logic crc,
                       input logic irqen, input logic wrap, input logic [8:0] st);
    logic [31:0] w, a, wexp;
    logic [15:0] el;
    serial++;
    a = 32'hC0DE_0000 | 32'(serial);
    w = {len, 1'b1, irqen, wrap, pad, crc, 2'b10, 9'h1AB};
    wexp = {len, 1'b0, irqen, wrap, pad, crc, 2'b10, st};
    el = (pad && len < 16'd64) ? 16'd64 : len;
    hwrite(saddr(exp_idx) + 12'd4, a);
    hwrite(saddr(exp_idx), w);
    serve(tag, a, el, pad, crc, st);
    after_frame(tag, wexp, a, irqen, st);
    exp_idx = nxt(exp_idx, wrap);
  endtask

  task automatic clear_src();
    hwrite(12'h004, 32'h3);
    src_exp = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] lens [7];
    bit idle_ok;
    lens = '{16'd0, 16'd1, 16'd40, 16'd63, 16'd64, 16'd65, 16'd1500};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    hread(12'h000, rd); check("R1 mode", rd, 32'd0);
    hread(12'h004, rd); check("R1 source", rd, 32'd0);
    hread(12'h008, rd); check("R1 mask", rd, 32'd0);
    hread(12'h00C, rd); check("R1 count", rd, 32'(NDESC));
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 snd_req", 32'(snd_req), 32'd0);

    // R2 register map
    hwrite(12'h00C, 32'd20); hread(12'h00C, rd); check("R2 count clamp", rd, 32'(NDESC));
    hwrite(12'h00C, 32'd4);  hread(12'h00C, rd); check("R2 count write", rd, 32'd4);
    count_m = 4;
    hwrite(12'h008, 32'h3);  hread(12'h008, rd); check("R2 mask", rd, 32'h3);
    mask_m = 2'b11;
    hwrite(saddr(7) + 12'd4, 32'h1234_5678); hread(saddr(7) + 12'd4, rd);
    check("R2 descriptor word", rd, 32'h1234_5678);
    hwrite(12'h000, 32'h1);  hread(12'h000, rd); check("R2 mode", rd, 32'h1);

    // R7 laps at count 4, R6 single steps
    for (int i = 0; i < 6; i++)
      frame("R7 lap", 16'(100 + i), 1'b0, i[0], 1'b1, 1'b0, 9'h050);
    clear_src();

    // R4 padding sweep
    for (int p = 0; p < 2; p++)
      for (int j = 0; j < 7; j++)
        frame("R4 pad sweep", lens[j], p[0], j[0], 1'b0, 1'b0, 9'(j));

    // R8 each status bit alone
    for (int b = 0; b < 9; b++) begin
      clear_src();
      frame("R8 status bit", 16'd200, 1'b1, 1'b1, 1'b1, 1'b0, 9'(1 << b));
    end
    clear_src();
    frame("R8 no irq request", 16'd80, 1'b0, 1'b1, 1'b0, 1'b0, 9'h108);

    // R6 wrap bit at count 8
    hwrite(12'h00C, 32'd8); count_m = 8;
    if (exp_idx == 0) frame("R6 step", 16'd90, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0);
    frame("R6 step", 16'd91, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0);
    frame("R6 wrap", 16'd92, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0);
    check("R6 index after wrap", 32'(exp_idx), 32'd0);
    frame("R6 after wrap", 16'd93, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0);

    // R9 mask gating and write-one-to-clear
    hwrite(12'h008, 32'h1); mask_m = 2'b01;
    frame("R9 masked error", 16'd70, 1'b0, 1'b0, 1'b1, 1'b0, 9'h004);
    check("R9 masked irq low", 32'(irq), 32'd0);
    hwrite(12'h008, 32'h3); mask_m = 2'b11;
    check("R9 unmasked irq high", 32'(irq), 32'd1);
    frame("R9 sent", 16'd71, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000);
    hwrite(12'h004, 32'h1); hread(12'h004, rd);
    check("R9 clear bit0 only", rd, 32'h2);
    hwrite(12'h004, 32'h0); hread(12'h004, rd);
    check("R9 write zero keeps", rd, 32'h2);
    hwrite(12'h004, 32'h2); hread(12'h004, rd);
    check("R9 clear bit1", rd, 32'h0);
    check("R9 irq low after clear", 32'(irq), 32'd0);
    src_exp = 2'b00;

    // R11 descriptor not ready is skipped until ready
    hwrite(saddr(exp_idx) + 12'd4, 32'hBEEF_0011);
    hwrite(saddr(exp_idx), {16'd300, 1'b0, 6'b000000, 9'h000});
    idle_ok = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (snd_req) idle_ok = 0;
    end
    check("R11 not ready not sent", 32'(idle_ok), 32'd1);
    hread(saddr(exp_idx), rd);
    check("R11 word untouched", rd, {16'd300, 16'h0000});
    hwrite(saddr(exp_idx), {16'd300, 1'b1, 6'b000000, 9'h000});
    serve("R11 sent once ready", 32'hBEEF_0011, 16'd300, 1'b0, 1'b0, 9'h0);
    after_frame("R11", {16'd300, 16'h0000}, 32'hBEEF_0011, 1'b0, 9'h0);
    exp_idx = nxt(exp_idx, 1'b0);

    // R10 disable holds and returns index to 0
    if (exp_idx == 0) frame("R10 step", 16'd95, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0);
    hwrite(12'h000, 32'h0);
    exp_idx = 0;
    hwrite(saddr(0) + 12'd4, 32'hFACE_0000);
    hwrite(saddr(0), {16'd128, 1'b1, 6'b000001, 9'h000});
    idle_ok = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (snd_req) idle_ok = 0;
    end
    check("R10 disabled no start", 32'(idle_ok), 32'd1);
    hread(saddr(0), rd);
    check("R10 ready kept", rd, {16'd128, 1'b1, 6'b000001, 9'h000});
    hwrite(12'h000, 32'h1);
    serve("R10 resumes at 0", 32'hFACE_0000, 16'd128, 1'b0, 1'b0, 9'h0A0);
    after_frame("R10", {16'd128, 1'b0, 6'b000001, 9'h0A0}, 32'hFACE_0000, 1'b0, 9'h0A0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule